// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a serial EEPROM on a two-wire bus. Its capacity is set at build time to 2, 4, 8 or 16 kbit. It samples the clock and data lines in the system clock domain and finds start and stop conditions. A start is data falling while the clock is high. A stop is data rising while the clock is high. After a start it takes an 8-bit select byte: the fixed group 1010, then three positions, then a read/write flag. The top bits of the three positions are checked against strap pins. The low positions that the density leaves unused carry the high word-address bits instead.

A write transfer sends one word-address byte and then any number of data bytes. Each data byte goes into a register array, and the address steps within the current page. A read transfer either continues from the internal address or follows a repeated start after a word address. Each byte the master acknowledges moves the address on by one across the whole array. The block only ever pulls the data line low, through an enable output. A protect input turns every write into an acknowledged no-op. A stop that ends a transfer in which a byte was stored starts a busy interval, and select bytes are not acknowledged while it runs.

Top module: `eeprom_slave`

## Requirements
- R1: After reset, and whenever the block is idle, `sda_oe_o` is low, so the data line is released.
- R2: A select byte is acknowledged (data pulled low during the ninth clock) only if its bits [7:4] are 1010 and every compared strap position matches `strap_i`. The compared positions are bit 3 = strap[2], bit 2 = strap[1] and bit 1 = strap[0]. A select byte that does not match gets no acknowledge.
- R3: A write of a word address and a data byte stores the byte. A later random read of that address returns it, MSB first.
- R4: During a multi-byte write, the low address bits (3 bits for 2 kbit, 4 bits otherwise) wrap within the current page. Bytes in other pages are left unchanged.
- R5: During a sequential read the address increments across the whole array and rolls over from the last byte to address 0.
- R6: A read that follows a select byte without a word address returns the byte after the last one accessed.
- R7: With `wp_i` high, write bytes are still acknowledged but the array is unchanged, and no busy interval starts.
- R8: After a stop that ends a transfer that stored at least one byte, select bytes get no acknowledge for `BUSY_CYCLES` clocks. After that they are acknowledged again.
- R9: For densities above 2 kbit, the unused low select positions (bit 1 upward) supply word-address bits 8 and up, and they are not compared with the straps.
- R10: `sda_oe_o` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (after wired-AND) |
| strap_i | input | 3 | Hard-wired device address straps |
| wp_i | input | 1 | Write protect, high blocks all array writes |
| sda_oe_o | output | 1 | Pull data line low when high |

## Verification
A wrong bit counter or a wrong state shows up at the ports within one byte time. The acknowledge slot moves, or data bits leave one clock early or late, and the next byte compare fails. A wrong address register does not show during the write. It shows on the next read, as a byte that does not match the one expected, such as a missing page wrap or a missing rollover to address 0. A wrong busy counter shows as an acknowledge or a missing acknowledge on the first select byte after a write.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK
    } ee_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam logic [3:0] SEL_GROUP = 4'b1010;

    function automatic int addr_bits_f(input int kbit);
        case (kbit)
            2:       return 8;
            4:       return 9;
            8:       return 10;
            default: return 11;
        endcase
    endfunction

    function automatic int page_bits_f(input int kbit);
        return (kbit == 2) ? 3 : 4;
    endfunction

    // Strap position i sits at select bit i+1; positions below hi carry address bits.
    function automatic logic select_match(input logic [7:0] sel,
                                          input logic [2:0] strap,
                                          input int hi);
        logic ok;
        ok = (sel[7:4] == SEL_GROUP);
        for (int i = 0; i < 3; i++) begin
            if (i >= hi && sel[i+1] != strap[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/eeprom_bus_sense.sv
module eeprom_bus_sense
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [1:0] s1, s2, prev;  // {scl, sda}

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 2'b11;
            s2   <= 2'b11;
            prev <= 2'b11;
        end else begin
            s1   <= {scl_i, sda_i};
            s2   <= s1;
            prev <= s2;
        end
    end

    always_comb begin
        ev_o.scl   = s2[1];
        ev_o.sda   = s2[0];
        ev_o.rise  = s2[1] & ~prev[1];
        ev_o.fall  = ~s2[1] & prev[1];
        ev_o.start = s2[1] & prev[1] & prev[0] & ~s2[0];
        ev_o.stop  = s2[1] & prev[1] & ~prev[0] & s2[0];
    end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
    end

    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start_i)       cnt <= CW'(CYCLES);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int DENSITY_KBIT = 4,
    parameter int BUSY_CYCLES  = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int AW = addr_bits_f(DENSITY_KBIT);
    localparam int PB = page_bits_f(DENSITY_KBIT);
    localparam int HI = AW - 8;

    bus_ev_t       ev;
    ee_state_e     st;
    logic [3:0]    cnt;
    logic [7:0]    sh;
    logic [2:0]    sel_hi_q;
    logic          rw_q;
    logic          mack_q;
    logic          stored_q;
    logic [AW-1:0] addr;
    logic [AW-1:0] addr_pg;
    logic [7:0]    mem_rd;
    logic          mem_we;
    logic          busy;
    logic          busy_start;
    logic          byte_in;
    logic          scl_lvl;

    eeprom_bus_sense sense_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eeprom_array #(.AW(AW)) array_i (
        .clk     (clk),
        .we_i    (mem_we),
        .addr_i  (addr),
        .wdata_i (sh),
        .rdata_o (mem_rd)
    );

    eeprom_busy_timer #(.CYCLES(BUSY_CYCLES)) busy_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (busy_start),
        .busy_o  (busy)
    );

    assign scl_lvl    = ev.scl;
    assign byte_in    = ev.fall && (cnt == 4'd8);
    assign busy_start = ev.stop && stored_q;
    assign mem_we     = (st == ST_WDATA) && byte_in && !wp_i && !ev.start && !ev.stop;

    always_comb begin
        addr_pg = addr;
        addr_pg[PB-1:0] = addr[PB-1:0] + PB'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            sel_hi_q <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            stored_q <= 1'b0;
            addr     <= '0;
            sda_oe_o <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_DEV;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
        end else if (ev.stop) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            stored_q <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            case (st)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    if (ev.rise && cnt != 4'd8) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (byte_in) begin
                        cnt <= '0;
                        if (st == ST_DEV) begin
                            if (select_match(sh, strap_i, HI) && !busy) begin
                                sel_hi_q <= sh[3:1];
                                rw_q     <= sh[0];
                                sda_oe_o <= 1'b1;
                                st       <= ST_DEV_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else if (st == ST_ADDR) begin
                            addr     <= AW'({sel_hi_q, sh});
                            sda_oe_o <= 1'b1;
                            st       <= ST_ADDR_ACK;
                        end else begin
                            if (!wp_i) stored_q <= 1'b1;
                            addr     <= addr_pg;
                            sda_oe_o <= 1'b1;
                            st       <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev.fall) begin
                        if (rw_q) begin
                            sh       <= mem_rd;
                            sda_oe_o <= ~mem_rd[7];
                            st       <= ST_RDATA;
                        end else begin
                            sda_oe_o <= 1'b0;
                            st       <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR_ACK, ST_WDATA_ACK: begin
                    if (ev.fall) begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (ev.fall) begin
                        if (cnt == 4'd7) begin
                            cnt      <= '0;
                            sda_oe_o <= 1'b0;
                            addr     <= addr + 1'b1;
                            st       <= ST_RDATA_ACK;
                        end else begin
                            sh       <= {sh[6:0], 1'b0};
                            sda_oe_o <= ~sh[6];
                            cnt      <= cnt + 1'b1;
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (ev.rise) begin
                        mack_q <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (mack_q) begin
                            sh       <= mem_rd;
                            sda_oe_o <= ~mem_rd[7];
                            st       <= ST_RDATA;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
    import eeprom_pkg::*;
#(
    parameter int AW = 9,
    parameter int PB = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_lvl,
    input logic          sda_oe,
    input ee_state_e     st,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] addr,
    input logic [3:0]    sel_top
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R2
    sel_group_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV_ACK && sda_oe) |-> (sel_top == 4'b1010));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (addr[AW-1:PB] == $past(addr[AW-1:PB])));

    // R8
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV_ACK && sda_oe) |-> !busy);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_lvl));
endmodule

bind eeprom_slave eeprom_slave_chk #(.AW(AW), .PB(PB)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (scl_lvl),
    .sda_oe  (sda_oe_o),
    .st      (st),
    .busy    (busy),
    .mem_we  (mem_we),
    .addr    (addr),
    .sel_top (sh[7:4])
);

// File: tb/eeprom_slave_tb_top.sv
module eeprom_slave_tb_top;
    localparam logic [2:0] PINS = 3'b010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];
    logic [7:0] wbuf[16];
    logic [7:0] rbuf[16];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    eeprom_slave #(.DENSITY_KBIT(4), .BUSY_CYCLES(300)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (m_scl),
        .sda_i    (sda_bus),
        .strap_i  (PINS),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // Monitor: pops expected/actual pairs and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] e, a;
                string t;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic push(input logic [7:0] e, input logic [7:0] a, input string t);
        exp_q.push_back(e);
        act_q.push_back(a);
        tag_q.push_back(t);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        wait_clk(6); m_sda = b;
        wait_clk(6); m_scl = 1'b1;
        wait_clk(8); m_scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wait_clk(6); m_sda = 1'b1;
        wait_clk(6); m_scl = 1'b1;
        wait_clk(4); b = sda_bus;
        wait_clk(4); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_clk(6); m_sda = 1'b1;
        wait_clk(6); m_scl = 1'b1;
        wait_clk(8); m_sda = 1'b0;
        wait_clk(8); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(6); m_sda = 1'b0;
        wait_clk(6); m_scl = 1'b1;
        wait_clk(8); m_sda = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string t);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        push({7'b0, exp_ack}, {7'b0, ~b}, t);
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic give_ack, input string t);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
        push(e, v, t);
    endtask

    function automatic logic [7:0] sel(input logic [8:0] a, input logic rw);
        return {4'b1010, PINS[2], PINS[1], a[8], rw};
    endfunction

    task automatic ee_write(input logic [8:0] a, input int n, input string t);
        bus_start();
        send_byte(sel(a, 1'b0), 1'b1, t);
        send_byte(a[7:0], 1'b1, t);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], 1'b1, t);
        bus_stop();
    endtask

    task automatic ee_read(input logic [8:0] a, input int n, input string t);
        bus_start();
        send_byte(sel(a, 1'b0), 1'b1, t);
        send_byte(a[7:0], 1'b1, t);
        bus_start();
        send_byte(sel(a, 1'b1), 1'b1, t);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1, t);
        bus_stop();
    endtask

    task automatic ee_cur(input int n, input string t);
        bus_start();
        send_byte(sel(9'h0, 1'b1), 1'b1, t);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1, t);
        bus_stop();
    endtask

    task automatic finish_run();
        wait_clk(10);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R1: line released after reset
        push(8'h00, {7'b0, sda_oe}, "R1 reset release");

        // R2: strap mismatch at compared position A2 gets no acknowledge
        bus_start();
        send_byte({4'b1010, 1'b1, PINS[1], 1'b0, 1'b0}, 1'b0, "R2 strap mismatch nack");
        bus_stop();
        // R2: wrong group nibble
        bus_start();
        send_byte({4'b1011, PINS[2], PINS[1], 1'b0, 1'b0}, 1'b0, "R2 group mismatch nack");
        bus_stop();

        // R3: two-byte write at 0x005, then random read
        wbuf[0] = 8'hA5; wbuf[1] = 8'h66;
        ee_write(9'h005, 2, "R3 write ack");
        wait_clk(400);
        rbuf[0] = 8'hA5;
        ee_read(9'h005, 1, "R3 random read");
        // R6: current-address read returns the next byte
        rbuf[0] = 8'h66;
        ee_cur(1, "R6 current read");

        // R4 / R9: page write in the upper half wraps inside its page
        wbuf[0] = 8'hEE;
        ee_write(9'h110, 1, "R9 upper write");
        wait_clk(400);
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h30 + 8'(i);
        ee_write(9'h10C, 8, "R4 page write");
        wait_clk(400);
        rbuf[0] = 8'h34; rbuf[1] = 8'h35; rbuf[2] = 8'h36; rbuf[3] = 8'h37;
        ee_read(9'h100, 4, "R4 wrapped bytes");
        rbuf[0] = 8'h30; rbuf[1] = 8'h31; rbuf[2] = 8'h32; rbuf[3] = 8'h33; rbuf[4] = 8'hEE;
        ee_read(9'h10C, 5, "R4 next page untouched");

        // R5: rollover from the last byte to address 0
        wbuf[0] = 8'h9F;
        ee_write(9'h1FF, 1, "R5 write top");
        wait_clk(400);
        wbuf[0] = 8'h0F;
        ee_write(9'h000, 1, "R5 write zero");
        wait_clk(400);
        rbuf[0] = 8'h9F; rbuf[1] = 8'h0F;
        ee_read(9'h1FF, 2, "R5 rollover read");

        // R7: protected write is acknowledged, array unchanged, no busy
        wp = 1'b1;
        wbuf[0] = 8'h11;
        ee_write(9'h005, 1, "R7 protected write ack");
        wp = 1'b0;
        rbuf[0] = 8'hA5;
        ee_read(9'h005, 1, "R7 protected unchanged");

        // R8: busy after a stored write
        wbuf[0] = 8'h42;
        ee_write(9'h020, 1, "R8 write");
        bus_start();
        send_byte(sel(9'h020, 1'b0), 1'b0, "R8 busy nack");
        bus_stop();
        wait_clk(400);
        rbuf[0] = 8'h42;
        ee_read(9'h020, 1, "R8 ack after busy");

        wait_clk(20);
        done = 1;
        finish_run();
    end
endmodule